// File: doc/BRIEF.md
# LPDDR2 Power-Up Initialization Sequencer

This block steps an LPDDR2 device through its power-up sequence once the memory clock is running. After a start pulse it counts memory clocks through a fixed chain of programmed phases. First comes a clock-settle wait with clock enable held low. Clock enable is then raised, and after a second wait the block sends a reset command. A third wait follows, after which the block polls the device status with mode-register reads until the device reports that it is no longer busy.

A fourth programmed count limits the whole stretch from the reset command to completion. If that limit runs out before a not-busy read arrives, polling stops and the block raises an error flag instead of the done flag. A mode input selects a plain flow that skips the reset and polling stages entirely and finishes as soon as clock enable is raised.

Each phase lasts its programmed count in clocks, and a count of zero is treated as one clock. A new start pulse is accepted only when the block is idle or has finished. Such a pulse replays the whole sequence from the settle phase.

Top module: `lpddr_pwrup_seq`

## Requirements
- R1: After reset, `cke_o`, `cmd_vld_o`, `done_o` and `err_o` are all low, and they stay low until a start pulse arrives.
- R2: `cke_o` rises max(D0,1) clocks after the edge that samples `start_i`, where D0 is `dly_settle_i`.
- R3: Once `cke_o` is high it stays high, including after an error, until a start pulse is accepted from the done or error state. Such a start drives it low again.
- R4: In LPDDR2 mode, max(D1,1) clocks after `cke_o` rises, a single-cycle command is issued with `cmd_code_o` = 1 (mode-register write) and `cmd_ma_o` = 63. D1 is `dly_cke_rst_i`. Every command appears only while `cke_o` is high.
- R5: If no timeout has occurred first, the first status read is issued max(D2,1) clocks after the reset command, with `cmd_code_o` = 2 and `cmd_ma_o` = `STATUS_MA` (0). D2 is `dly_rst_rd_i`. The read then repeats every `POLL_GAP` clocks while polling continues.
- R6: While polling, a cycle with `rd_valid_i` high and `rd_data_i[0]` = 0 makes `done_o` rise on the next clock. A response with bit 0 = 1 means the device is busy, and polling continues.
- R7: Let D3 be `dly_limit_i`. If no not-busy response has been taken by max(D3,1) clocks after the reset command, `err_o` rises at that clock and no further command is issued. A not-busy response sampled on that same edge wins, and the block reports done. If D2 ≥ D3, no read is issued at all.
- R8: With `lp2_mode_i` low, `done_o` rises in the same cycle as `cke_o` and no command is ever issued.
- R9: A delay count of zero gives a phase of exactly one clock.
- R10: A start pulse while a sequence is running has no effect on any output timing. A start pulse after done or error restarts the sequence from the settle phase.
- R11: `done_o` and `err_o` are never high together. Each one holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| lp2_mode_i | input | 1 | 1: full LPDDR2 flow; 0: finish at clock enable |
| dly_settle_i | input | CNT_W | Clocks from start to clock enable (D0) |
| dly_cke_rst_i | input | CNT_W | Clocks from clock enable to reset command (D1) |
| dly_rst_rd_i | input | CNT_W | Clocks from reset command to first status read (D2) |
| dly_limit_i | input | CNT_W | Maximum clocks from reset command to completion (D3) |
| rd_valid_i | input | 1 | Status read data valid |
| rd_data_i | input | DATA_W | Status read data; bit 0 = device busy |
| cke_o | output | 1 | Clock enable to the device |
| cmd_vld_o | output | 1 | Command strobe, one cycle per command |
| cmd_code_o | output | 2 | 0 none, 1 mode-register write, 2 mode-register read |
| cmd_ma_o | output | ADDR_W | Mode-register address of the command |
| done_o | output | 1 | Initialization complete |
| err_o | output | 1 | Completion limit expired |

## Verification
The assertions assume three things about the inputs. The four delay counts and the mode bit stay constant while a sequence runs. Read responses come only as answers to issued status reads. The start request is a single-cycle pulse. The bench changes mode and delays only before a start, or while the block sits in done or error. Its read responder returns data a fixed two cycles after each read strobe it observes, and it never answers on its own. The bench's only extra start pulse lands mid-sequence, where it must have no effect.

// File: rtl/lpddr_pwrup_pkg.sv
package lpddr_pwrup_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_CKE_WAIT,
      ST_RST_WAIT,
      ST_POLL,
      ST_DONE,
      ST_ERR
   } seq_state_e;

   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_MRW = 2'd1,
      CMD_MRR = 2'd2
   } cmd_e;

   localparam int unsigned RESET_MA = 63;

endpackage

// File: rtl/lpddr_pwrup_timer.sv
// Saturating clock counter: expire_o is high in the last cycle of a phase
// whose length is max(dly_i,1), counted from the cycle after clr_i.
module lpddr_pwrup_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] dly_i,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;

   assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
   assign expire_o = (cnt_inc >= {1'b0, dly_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clr_i)            cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/lpddr_pwrup_gap.sv
// Poll-interval tick: high once every GAP clocks while clr_i is low,
// first tick GAP-1 clocks after clr_i falls.
module lpddr_pwrup_gap #(
   parameter int unsigned GAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   generate
      if (GAP == 1) begin : g_every
         assign tick_o = ~clr_i;
      end else begin : g_count
         localparam int unsigned GW = $clog2(GAP);
         localparam logic [GW-1:0] LAST = GW'(GAP - 1);
         logic [GW-1:0] gcnt_q;

         assign tick_o = ~clr_i & (gcnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            gcnt_q <= '0;
            else if (clr_i)        gcnt_q <= '0;
            else if (gcnt_q == LAST) gcnt_q <= '0;
            else                   gcnt_q <= gcnt_q + 1'b1;
         end

         a_r5_tick_spacing : assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/lpddr_pwrup_seq.sv
module lpddr_pwrup_seq
   import lpddr_pwrup_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned POLL_GAP  = 4,
   parameter int unsigned STATUS_MA = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              lp2_mode_i,
   input  logic [CNT_W-1:0]  dly_settle_i,
   input  logic [CNT_W-1:0]  dly_cke_rst_i,
   input  logic [CNT_W-1:0]  dly_rst_rd_i,
   input  logic [CNT_W-1:0]  dly_limit_i,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              cke_o,
   output logic              cmd_vld_o,
   output logic [1:0]        cmd_code_o,
   output logic [ADDR_W-1:0] cmd_ma_o,
   output logic              done_o,
   output logic              err_o
);
   localparam logic [ADDR_W-1:0] MA_RESET  = ADDR_W'(RESET_MA);
   localparam logic [ADDR_W-1:0] MA_STATUS = ADDR_W'(STATUS_MA);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must hold mode-register address 63");
      end
      if (POLL_GAP < 1) begin : g_bad_gap
         $error("POLL_GAP must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   seq_state_e       st_q, st_d;
   logic             ph_exp, lim_exp, gap_tick;
   logic             iss_mrw, iss_mrr, cke_set, cke_clr;
   logic [CNT_W-1:0] ph_dly;
   logic             cke_q, cmd_vld_q;
   cmd_e             cmd_code_q;
   logic [ADDR_W-1:0] cmd_ma_q;
   logic             rd_ready;

   assign rd_ready = rd_valid_i & ~rd_data_i[0];

   always_comb begin
      unique case (st_q)
         ST_SETTLE:   ph_dly = dly_settle_i;
         ST_CKE_WAIT: ph_dly = dly_cke_rst_i;
         ST_RST_WAIT: ph_dly = dly_rst_rd_i;
         default:     ph_dly = '0;
      endcase
   end

   always_comb begin
      st_d    = st_q;
      iss_mrw = 1'b0;
      iss_mrr = 1'b0;
      cke_set = 1'b0;
      cke_clr = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start_i) st_d = ST_SETTLE;
         ST_SETTLE: if (ph_exp) begin
            cke_set = 1'b1;
            st_d    = lp2_mode_i ? ST_CKE_WAIT : ST_DONE;
         end
         ST_CKE_WAIT: if (ph_exp) begin
            iss_mrw = 1'b1;
            st_d    = ST_RST_WAIT;
         end
         ST_RST_WAIT: begin
            if (lim_exp) st_d = ST_ERR;
            else if (ph_exp) begin
               iss_mrr = 1'b1;
               st_d    = ST_POLL;
            end
         end
         ST_POLL: begin
            if (rd_ready)      st_d = ST_DONE;
            else if (lim_exp)  st_d = ST_ERR;
            else if (gap_tick) iss_mrr = 1'b1;
         end
         ST_DONE, ST_ERR: if (start_i) begin
            cke_clr = 1'b1;
            st_d    = ST_SETTLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   lpddr_pwrup_timer #(.CNT_W(CNT_W)) u_phase_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (st_d != st_q),
      .dly_i   (ph_dly),
      .expire_o(ph_exp)
   );

   lpddr_pwrup_timer #(.CNT_W(CNT_W)) u_limit_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (iss_mrw),
      .dly_i   (dly_limit_i),
      .expire_o(lim_exp)
   );

   lpddr_pwrup_gap #(.GAP(POLL_GAP)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (st_q != ST_POLL),
      .tick_o(gap_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cke_q      <= 1'b0;
         cmd_vld_q  <= 1'b0;
         cmd_code_q <= CMD_NOP;
         cmd_ma_q   <= '0;
      end else begin
         st_q      <= st_d;
         cmd_vld_q <= iss_mrw | iss_mrr;
         if (cke_set)      cke_q <= 1'b1;
         else if (cke_clr) cke_q <= 1'b0;
         if (iss_mrw) begin
            cmd_code_q <= CMD_MRW;
            cmd_ma_q   <= MA_RESET;
         end else if (iss_mrr) begin
            cmd_code_q <= CMD_MRR;
            cmd_ma_q   <= MA_STATUS;
         end else begin
            cmd_code_q <= CMD_NOP;
            cmd_ma_q   <= '0;
         end
      end
   end

   assign cke_o      = cke_q;
   assign cmd_vld_o  = cmd_vld_q;
   assign cmd_code_o = cmd_code_q;
   assign cmd_ma_o   = cmd_ma_q;
   assign done_o     = (st_q == ST_DONE);
   assign err_o      = (st_q == ST_ERR);

   a_r3_cke_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (cke_o && !(start_i && (done_o || err_o))) |=> cke_o);

   a_r4_cmd_needs_cke : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld_o |-> cke_o);

   a_r4_reset_single : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_o && cmd_code_o == 2'd1) |=> !(cmd_vld_o && cmd_code_o == 2'd1));

   a_r6_done_cause : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_o) && lp2_mode_i) |-> $past(rd_valid_i && !rd_data_i[0]));

   a_r7_quiet_after_end : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || err_o) |-> !cmd_vld_o);

   a_r8_no_cmd_plain : assert property (@(posedge clk) disable iff (!rst_n)
      !lp2_mode_i |-> !cmd_vld_o);

   a_r11_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

endmodule

// File: tb/lpddr_pwrup_seq_bench.sv
module lpddr_pwrup_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W  = 16;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 8;
   localparam int GAP    = 4;
   localparam int LAT    = 2;
   localparam int NVEC   = 7;

   // lp2, d0, d1, d2, d3, busy_reads
   localparam int VEC [NVEC][6] = '{
      '{1, 5, 3, 4, 40, 2},   // R6 busy then ready
      '{1, 0, 0, 0, 20, 0},   // R9 zero counts
      '{1, 2, 2, 3, 12, 9},   // R7 timeout while polling
      '{0, 4, 9, 9, 9, 0},    // R8 plain mode
      '{1, 3, 1, 10, 6, 0},   // R7 limit before first read
      '{1, 1, 1, 1, 8, 1},    // R7 tie: ready wins
      '{1, 1, 1, 1, 1, 0}     // R9 one-clock limit
   };
   localparam string TAG [NVEC] = '{"R6", "R9", "R7", "R8", "R7", "R7", "R9"};

   logic clk = 0, rst_n = 0, start = 0, lp2 = 1;
   logic [CNT_W-1:0] d0 = '0, d1 = '0, d2 = '0, d3 = '0;
   logic rd_valid = 0;
   logic [DATA_W-1:0] rd_data = '0;
   logic cke, cmd_vld, done, err;
   logic [1:0] cmd_code;
   logic [ADDR_W-1:0] cmd_ma;

   int n_tests = 0, n_fail = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpddr_pwrup_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                     .POLL_GAP(GAP), .STATUS_MA(0)) u_lpddr_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .lp2_mode_i(lp2),
      .dly_settle_i(d0), .dly_cke_rst_i(d1), .dly_rst_rd_i(d2), .dly_limit_i(d3),
      .rd_valid_i(rd_valid), .rd_data_i(rd_data),
      .cke_o(cke), .cmd_vld_o(cmd_vld), .cmd_code_o(cmd_code), .cmd_ma_o(cmd_ma),
      .done_o(done), .err_o(err));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run did not finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; start = 0; rd_valid = 0; rd_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   function automatic int mx1(input int v);
      return (v < 1) ? 1 : v;
   endfunction

   task automatic run_seq(input string tag, input int vl, input int v0, input int v1,
                          input int v2, input int v3, input int busy,
                          input int ign_t, input bit with_reset);
      int t_cke = -1, t_rst = -1, rst_ma = -1, t_mrr = -1, mrr_ma = -1;
      int n_mrr = 0, t_end = -1, end_err = 0;
      bit cke_drop = 0, late_cmd = 0, lost_end = 0, both = 0;
      bit p0 = 0, p1 = 0;
      int resp_idx = 0, t = 0;
      int n0, n1, n2, n3, r, m, e_end, e_err, e_nmrr;

      if (with_reset) do_reset();
      lp2 = vl[0]; d0 = CNT_W'(v0); d1 = CNT_W'(v1); d2 = CNT_W'(v2); d3 = CNT_W'(v3);
      start = 1;
      @(negedge clk);
      start = 0;
      while (!(t_end >= 0 && t >= t_end + 3) && t < 400) begin
         if (cke && t_cke < 0) t_cke = t;
         if (t_cke >= 0 && !cke) cke_drop = 1;
         if (cmd_vld) begin
            if (t_end >= 0) late_cmd = 1;
            if (cmd_code == 2'd1 && t_rst < 0) begin t_rst = t; rst_ma = int'(cmd_ma); end
            if (cmd_code == 2'd2) begin
               if (t_mrr < 0) begin t_mrr = t; mrr_ma = int'(cmd_ma); end
               n_mrr++;
            end
         end
         if ((done || err) && t_end < 0) begin t_end = t; end_err = int'(err); end
         if (t_end >= 0 && !(done || err)) lost_end = 1;
         if (done && err) both = 1;
         rd_valid = p1;
         rd_data  = {{(DATA_W-1){1'b0}}, (resp_idx < busy)};
         if (p1) resp_idx++;
         p1 = p0;
         p0 = cmd_vld && cmd_code == 2'd2;
         start = (t == ign_t);
         @(negedge clk);
         t++;
      end
      rd_valid = 0; start = 0;

      n0 = mx1(v0); n1 = mx1(v1); n2 = mx1(v2); n3 = mx1(v3);
      if (vl == 0) begin
         r = -1; m = -1; e_end = n0; e_err = 0; e_nmrr = 0;
      end else begin
         r = n0 + n1;
         m = (n2 < n3) ? r + n2 : -1;
         if (m >= 0 && (m + busy*GAP + LAT + 1 <= r + n3)) begin
            e_end = m + busy*GAP + LAT + 1; e_err = 0;
         end else begin
            e_end = r + n3; e_err = 1;
         end
         e_nmrr = (m < 0) ? 0 : (e_end - 1 - m) / GAP + 1;
      end

      check(t_cke == n0, {tag, " R2 cke rise time"}, t_cke, n0);
      check(t_rst == r, {tag, " R4 reset command time"}, t_rst, r);
      if (r >= 0) check(rst_ma == 63, {tag, " R4 reset address"}, rst_ma, 63);
      check(t_mrr == m, {tag, " R5 first status read time"}, t_mrr, m);
      if (m >= 0) check(mrr_ma == 0, {tag, " R5 status address"}, mrr_ma, 0);
      check(n_mrr == e_nmrr, {tag, " R5 poll read count"}, n_mrr, e_nmrr);
      check(t_end == e_end, {tag, e_err ? " R7 end time" : " R6 end time"}, t_end, e_end);
      check(end_err == e_err, {tag, " R7 end kind (1=err)"}, end_err, e_err);
      check(!cke_drop, {tag, " R3 cke held"}, int'(cke_drop), 0);
      check(!late_cmd, {tag, " R7 no command after end"}, int'(late_cmd), 0);
      check(!lost_end && !both, {tag, " R11 flag held and exclusive"},
            int'(lost_end) + 2*int'(both), 0);
   endtask

   initial begin
      // R1: reset state, nothing moves without start
      do_reset();
      repeat (4) @(negedge clk);
      check({cke, cmd_vld, done, err} == 4'b0000, "R1 idle outputs",
            int'({cke, cmd_vld, done, err}), 0);

      for (int i = 0; i < NVEC; i++)
         run_seq(TAG[i], VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
                 VEC[i][5], -1, 1'b1);

      // R10: start in mid-sequence is ignored
      run_seq("R10 ignored start", 1, 5, 3, 4, 40, 2, 6, 1'b1);
      // R10: restart after error without reset; R3 cke held while in error
      run_seq("R10 pre-restart", 1, 2, 2, 3, 12, 9, -1, 1'b1);
      run_seq("R10 restart after err", 1, 0, 0, 0, 20, 0, -1, 1'b0);
      run_seq("R10 restart after done", 0, 4, 9, 9, 9, 0, -1, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule